// File: doc/BRIEF.md
# Buffered Ratio Clock Prescaler

This block divides its clock by a programmable ratio and emits a one-clock count-enable pulse (a tick) for a timer counter that sits next to it. The ratio is a 16-bit value N. The tick rate is the clock rate divided by N + 1, so N = 0 divides by 1 and N = 0xFFFF divides by 65536.

Software writes a new ratio through a valid/ready port into a staging register. The ratio in use, called the active ratio, is copied from the staging register only when an update strobe or a reinitialize strobe arrives while updates are allowed. This lets the ratio change while the timer runs without a short or torn period. A reinitialize strobe also clears the internal count to zero. When updates are blocked it still does that, but the active ratio keeps its value.

The write port never applies back-pressure: `wr_ready_o` is always high. Every cycle with `wr_valid_i` high is accepted, and the last accepted value wins. The run input takes effect one clock later, through an internal enable register.

Top module: `psc_ratio_prescaler`

## Requirements
- R1: After reset the active ratio reads 0, the staging ratio is 0, the internal count is 0 and the tick is low.
- R2: The internal enable follows `run_i` with one cycle of delay. A tick can only appear in a cycle where the internal enable is high, so the first tick comes in the cycle after `run_i` first goes high.
- R3: While enabled with active ratio N and no strobes, the tick is high for one cycle in every N + 1 cycles. N = 0 gives a tick every cycle and N = 0xFFFF gives 65536 cycles between ticks.
- R4: An accepted write changes only the staging register. `ratio_o` and the tick spacing do not change until a later load.
- R5: A load copies the staging value held before that clock edge into the active ratio. A write in the same cycle as an update therefore takes effect only at the following load. The new ratio shows on `ratio_o` in the next cycle.
- R6: A reinitialize strobe clears the count to 0 at the clock edge and holds the tick low in its own cycle. With updates allowed it also loads the active ratio.
- R7: While `upd_dis_i` is high, neither the update strobe nor the reinitialize strobe changes the active ratio.
- R8: If the count is above a newly loaded smaller ratio, the next enabled cycle gives a tick and the count wraps to 0.
- R9: `wr_ready_o` is always high, so every write with `wr_valid_i` high is accepted.
- R10: After `run_i` falls, the block still counts for one cycle. After that the tick stays low and the count holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run request; it drives the internal enable one cycle later |
| wr_valid_i | input | 1 | Staging write valid |
| wr_ready_o | output | 1 | Staging write ready, always 1 |
| wr_data_i | input | W (16) | Ratio value N to stage |
| upd_i | input | 1 | Update strobe; loads the active ratio when updates are allowed |
| upd_dis_i | input | 1 | When high, blocks all loads of the active ratio |
| reinit_i | input | 1 | Reinitialize strobe; clears the count and loads the ratio when allowed |
| tick_o | output | 1 | One-cycle count-enable pulse |
| ratio_o | output | W (16) | Active ratio readback |

## Verification
Two functions can fall in the same clock cycle: a staging write and an update, and a reinitialize strobe and a tick that is due.

- **Write with update:** the vector table drives a write and an update together. The check is that `ratio_o` first shows the older staged value and only reaches the newly written value after a second update.
- **Reinitialize with a due tick:** the table drives a reinitialize strobe in a cycle where the count equals the active ratio, with updates blocked. The check is that the tick stays low, the count restarts from zero, and the ratio stays put.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int unsigned PSC_W_DEF = 16;

  typedef struct packed {
    logic load;   // copy staging ratio into active ratio
    logic clear;  // restart the division count
  } psc_ctl_t;
endpackage

// File: rtl/psc_run_sync.sv
module psc_run_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_o <= 1'b0;
    else        en_o <= run_i;
  end

  // R2 / R10: enable tracks run with one cycle of lag
  a_r2_en_follows: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> en_o);
  a_r10_en_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !en_o);
endmodule

// File: rtl/psc_ratio_buf.sv
module psc_ratio_buf #(
  parameter int unsigned W = psc_pkg::PSC_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         load_i,
  output logic [W-1:0] active_o
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      active_o <= '0;
    end else begin
      if (load_i)  active_o <= stage_q;
      if (wr_en_i) stage_q  <= wr_data_i;
    end
  end

  // R4: without a load the active ratio never moves
  a_r4_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(active_o));
  // R5: a load takes the staged value from before the edge
  a_r5_load_old_stage: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> active_o == $past(stage_q));
endmodule

// File: rtl/psc_div_count.sv
module psc_div_count #(
  parameter int unsigned W = psc_pkg::PSC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  psc_pkg::psc_ctl_t ctl_i,
  input  logic [W-1:0]      ratio_i,
  output logic              tick_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic         wrap;

  // compare with >= so a count above a freshly lowered ratio wraps at once
  assign wrap   = (cnt_q >= ratio_i);
  assign tick_o = en_i && !ctl_i.clear && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (ctl_i.clear) cnt_q <= '0;
    else if (en_i)       cnt_q <= wrap ? '0 : cnt_q + ONE;
  end

  // R6: reinitialize leaves a zero count
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_i.clear |=> cnt_q == '0);
  // R3: a tick restarts the count
  a_r3_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> cnt_q == '0);
  // R10: with no enable and no clear the count holds
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !ctl_i.clear) |=> $stable(cnt_q));
endmodule

// File: rtl/psc_ratio_prescaler.sv
module psc_ratio_prescaler #(
  parameter int unsigned W = psc_pkg::PSC_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         wr_valid_i,
  output logic         wr_ready_o,
  input  logic [W-1:0] wr_data_i,
  input  logic         upd_i,
  input  logic         upd_dis_i,
  input  logic         reinit_i,
  output logic         tick_o,
  output logic [W-1:0] ratio_o
);
  psc_pkg::psc_ctl_t ctl;
  logic              en;

  assign wr_ready_o = 1'b1;
  assign ctl.load   = (upd_i || reinit_i) && !upd_dis_i;
  assign ctl.clear  = reinit_i;

  psc_run_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (run_i),
    .en_o  (en)
  );

  psc_ratio_buf #(.W(W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_valid_i && wr_ready_o),
    .wr_data_i (wr_data_i),
    .load_i    (ctl.load),
    .active_o  (ratio_o)
  );

  psc_div_count #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en),
    .ctl_i   (ctl),
    .ratio_i (ratio_o),
    .tick_o  (tick_o)
  );

  // R7: blocked updates never alter the ratio
  a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    upd_dis_i |=> $stable(ratio_o));
  // R2: no tick in the cycle after run was low
  a_r2_no_early_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !tick_o);
  // R9: write port never stalls
  a_r9_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready_o);
endmodule

// File: tb/test_psc_ratio_prescaler.sv
module test_psc_ratio_prescaler;
  localparam int W = 16;
  localparam int NV = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, wv = 1'b0, upd = 1'b0, dis = 1'b0, reinit = 1'b0;
  logic [W-1:0] wd = '0;
  logic wr_ready, tick;
  logic [W-1:0] ratio;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;  // 50 MHz

  psc_ratio_prescaler #(.W(W)) i_psc_ratio_prescaler (
    .clk(clk), .rst_n(rst_n), .run_i(run), .wr_valid_i(wv), .wr_ready_o(wr_ready),
    .wr_data_i(wd), .upd_i(upd), .upd_dis_i(dis), .reinit_i(reinit),
    .tick_o(tick), .ratio_o(ratio)
  );

  // row: [41:38] req, [37] run, [36] wv, [35:20] wd, [19] upd, [18] reinit,
  //      [17] dis, [16] expected tick, [15:0] expected ratio
  localparam logic [41:0] VEC [NV] = '{
    {4'd2, 1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b0,16'h0000}, // R2 idle
    {4'd2, 1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b0,16'h0000}, // R2 enable lag
    {4'd3, 1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b1,16'h0000}, // R3 div by 1
    {4'd4, 1'b1,1'b1,16'h0002,1'b0,1'b0,1'b0, 1'b1,16'h0000}, // R4 stage 2
    {4'd5, 1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0, 1'b1,16'h0000}, // R5 update
    {4'd5, 1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b0,16'h0002}, // R5 new ratio
    {4'd3, 1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b0,16'h0002},
    {4'd3, 1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b1,16'h0002}, // R3 div by 3
    {4'd3, 1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b0,16'h0002},
    {4'd6, 1'b1,1'b0,16'h0000,1'b0,1'b1,1'b0, 1'b0,16'h0002}, // R6 reinit
    {4'd6, 1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b0,16'h0002},
    {4'd6, 1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b0,16'h0002},
    {4'd6, 1'b1,1'b1,16'h0005,1'b0,1'b1,1'b1, 1'b0,16'h0002}, // R6 tick held low
    {4'd7, 1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b0,16'h0002}, // R7 ratio kept
    {4'd6, 1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b0,16'h0002},
    {4'd6, 1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b1,16'h0002}, // R6 count from 0
    {4'd5, 1'b1,1'b1,16'h0001,1'b1,1'b0,1'b0, 1'b0,16'h0002}, // R5 write+update
    {4'd5, 1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b0,16'h0005}, // R5 old stage used
    {4'd5, 1'b1,1'b0,16'h0000,1'b1,1'b0,1'b0, 1'b0,16'h0005},
    {4'd8, 1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b1,16'h0001}, // R8 over-range wrap
    {4'd8, 1'b1,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b0,16'h0001},
    {4'd10,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b1,16'h0001}, // R10 one more cycle
    {4'd10,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b0,16'h0001}, // R10 stopped
    {4'd10,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b0,16'h0001}
  };

  function automatic string rname(input int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wv = 1'b0; upd = 1'b0; reinit = 1'b0; dis = 1'b0; wd = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0; idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    #(20ns * 190000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int gap;
    do_reset();
    check("R1", "tick after reset", tick, 0);
    check("R1", "ratio after reset", ratio, 0);
    check("R9", "ready", wr_ready, 1);

    // vector table: inputs applied at a falling edge, outputs sampled 1 ns later
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      run = VEC[i][37]; wv = VEC[i][36]; wd = VEC[i][35:20];
      upd = VEC[i][19]; reinit = VEC[i][18]; dis = VEC[i][17];
      #1;
      check(rname(int'(VEC[i][41:38])), $sformatf("tick row %0d", i), tick, VEC[i][16]);
      check(rname(int'(VEC[i][41:38])), $sformatf("ratio row %0d", i), ratio, VEC[i][15:0]);
    end

    // R7: a blocked update leaves the ratio (currently 1) alone
    @(negedge clk); idle_inputs(); wv = 1'b1; wd = 16'h0007;
    @(negedge clk); idle_inputs(); upd = 1'b1; dis = 1'b1;
    @(negedge clk); idle_inputs(); #1;
    check("R7", "ratio after blocked update", ratio, 16'h0001);

    // R1: reset in the middle of a run returns to divide-by-1
    run = 1'b1;
    do_reset();
    check("R1", "ratio after mid-run reset", ratio, 0);
    check("R1", "tick after mid-run reset", tick, 0);

    // R3: the largest ratio spaces ticks 65536 cycles apart
    @(negedge clk); run = 1'b1; wv = 1'b1; wd = 16'hFFFF;
    @(negedge clk); idle_inputs(); reinit = 1'b1;
    @(negedge clk); idle_inputs(); #1;
    check("R3", "ratio max loaded", ratio, 16'hFFFF);
    gap = 0;
    while (tick !== 1'b1 && gap < 70000) begin @(negedge clk); #1; gap++; end
    gap = 0;
    do begin @(negedge clk); #1; gap++; end while (tick !== 1'b1 && gap < 70000);
    check("R3", "cycles between ticks at max ratio", gap, 65536);
    run = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule